// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path. It watches the first six bytes of each incoming frame, assembles the 48-bit destination address, and decides whether the frame should be kept. A frame is kept when its destination equals the programmed station address, when it hits a valid entry of a small multicast match table, when it is the all-ones broadcast address, or when promiscuous mode is on. Frame reception, payload handling and frame check sequence checking happen elsewhere.

Software programs the filter through a simple write port. Each address is written as two 32-bit words, with the first received byte in the lowest byte lane. A multicast word pair also carries the table slot number in the upper half of the second word, and the entry takes effect only when that second word arrives. The decision appears one cycle after the sixth destination byte has been sampled and stays stable until the next frame begins, so it is ready long before the payload ends.

Top module: `rx_daf_filter`

## Requirements
- R1: After reset, decision_valid and accept are low, promiscuous mode is off and every multicast slot is empty, so a frame to a multicast address that was never programmed is dropped.
- R2: Select 0 loads destination bytes 0..3 (byte 0 is the first byte received) from write bits 7:0, 15:8, 23:16, 31:24; select 1 loads bytes 4 and 5 from bits 7:0 and 15:8; a frame whose destination equals this station address is accepted.
- R3: Bits 31:16 of a select 1 write have no effect on matching.
- R4: Select 2 stages bytes 0..3 of a multicast address; select 3 supplies bytes 4 and 5 in bits 15:0 and the slot number in bits 23:16, and writes the entry at that moment; a frame hitting any valid slot is accepted.
- R5: A select 3 write whose staged word and bits 15:0 are both zero empties the addressed slot, and frames to the old address are then dropped.
- R6: A select 3 write with a slot number of 4 or more (4 slots) changes no slot.
- R7: A destination of all ones is always accepted.
- R8: Select 4 bit 0 is the promiscuous bit; while set every frame is accepted, and once cleared normal filtering resumes.
- R9: A frame matching none of the above is dropped (decision_valid high, accept low).
- R10: decision_valid rises in the cycle after the sixth destination byte is sampled, and decision_valid and accept hold through any later bytes of the frame.
- R11: A byte flagged as frame start clears decision_valid on the next cycle and restarts address capture, even if the previous frame ended early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (0..4) |
| cfg_wdata | input | 32 | Configuration write data |
| rx_vld | input | 1 | Received byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_vld) |
| rx_byte | input | 8 | Received byte |
| decision_valid | output | 1 | Decision for the current frame is available |
| accept | output | 1 | Keep the current frame (meaningful while decision_valid is high) |

## Verification
The assertions take for granted that rx_vld and rx_sof are known after reset and that a configuration write landing in the same cycle as the sixth destination byte is judged with the settings from before that write; the promiscuous and broadcast properties therefore look at the promiscuous bit one cycle in the past. The stimulus keeps every configuration write between frames, drives all inputs on the falling edge, and mixes frames that end early, frames with trailing bytes and back-to-back starts, so the reference model and the design always see the same settled settings.

// File: rtl/rx_daf_pkg.sv
package rx_daf_pkg;

  localparam int MAC_W    = 48;
  localparam int MAC_BYTES = MAC_W / 8;
  localparam int SLOT_LSB = 16;
  localparam int SLOT_FW  = 8;

  typedef logic [MAC_W-1:0] mac_t;

  typedef enum logic [2:0] {
    SEL_UC_LO = 3'd0,
    SEL_UC_HI = 3'd1,
    SEL_MC_LO = 3'd2,
    SEL_MC_HI = 3'd3,
    SEL_MODE  = 3'd4
  } cfg_sel_e;

endpackage

// File: rtl/rx_daf_cfg.sv
module rx_daf_cfg
  import rx_daf_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_sel,
  input  logic [31:0]     wr_data,
  output mac_t            uc_addr,
  output logic            promisc,
  output logic            mc_we,
  output logic [IDXW-1:0] mc_idx,
  output mac_t            mc_addr,
  output logic            mc_set
);

  mac_t        uc_q, uc_d;
  logic        prom_q, prom_d;
  logic [31:0] stage_q, stage_d;
  logic        slot_ok;

  assign slot_ok = wr_data[SLOT_LSB +: SLOT_FW] < SLOT_FW'(SLOTS);

  always_comb begin
    uc_d    = uc_q;
    prom_d  = prom_q;
    stage_d = stage_q;
    if (wr_en) begin
      unique case (cfg_sel_e'(wr_sel))
        SEL_UC_LO: uc_d[31:0]  = wr_data;
        SEL_UC_HI: uc_d[47:32] = wr_data[15:0];
        SEL_MC_LO: stage_d     = wr_data;
        SEL_MODE:  prom_d      = wr_data[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_q    <= '0;
      prom_q  <= 1'b0;
      stage_q <= '0;
    end else if (wr_en) begin
      uc_q    <= uc_d;
      prom_q  <= prom_d;
      stage_q <= stage_d;
    end
  end

  assign uc_addr = uc_q;
  assign promisc = prom_q;
  assign mc_we   = wr_en && (wr_sel == SEL_MC_HI) && slot_ok;
  assign mc_idx  = wr_data[SLOT_LSB +: IDXW];
  assign mc_addr = {wr_data[15:0], stage_q};
  assign mc_set  = |mc_addr;

endmodule

// File: rtl/rx_daf_cam.sv
module rx_daf_cam
  import rx_daf_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  mac_t            wr_addr,
  input  logic            wr_set,
  input  mac_t            probe,
  output logic            hit
);

  logic [SLOTS-1:0] hit_vec;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    mac_t ent_q, ent_d;
    logic vld_q, vld_d;
    logic sel;

    assign sel = wr_en && (wr_idx == IDXW'(g));

    always_comb begin
      ent_d = ent_q;
      vld_d = vld_q;
      if (sel) begin
        ent_d = wr_addr;
        vld_d = wr_set;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        ent_q <= ent_d;
        vld_q <= vld_d;
      end
    end

    assign hit_vec[g] = vld_q && (ent_q == probe);
  end

  assign hit = |hit_vec;

endmodule

// File: rtl/rx_daf_capture.sv
module rx_daf_capture
  import rx_daf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic       rx_sof,
  input  logic [7:0] rx_byte,
  input  mac_t       uc_addr,
  input  logic       promisc,
  input  logic       mc_hit,
  output mac_t       probe,
  output mac_t       da,
  output logic       dec_vld,
  output logic       dec_acc
);

  localparam int CNTW = $clog2(MAC_BYTES + 1);
  localparam logic [CNTW-1:0] LAST = CNTW'(MAC_BYTES - 1);
  localparam logic [CNTW-1:0] IDLE = CNTW'(MAC_BYTES);

  logic [CNTW-1:0] cnt_q, cnt_d;
  mac_t            da_q, da_d;
  logic            vld_q, vld_d;
  logic            acc_q, acc_d;
  logic            match;

  always_comb begin
    probe = da_q;
    probe[MAC_W-1 -: 8] = rx_byte;
  end

  assign match = promisc || (probe == uc_addr) || mc_hit || (&probe);

  always_comb begin
    cnt_d = cnt_q;
    da_d  = da_q;
    vld_d = vld_q;
    acc_d = acc_q;
    if (rx_vld) begin
      if (rx_sof) begin
        da_d       = '0;
        da_d[7:0]  = rx_byte;
        cnt_d      = CNTW'(1);
        vld_d      = 1'b0;
        acc_d      = 1'b0;
      end else if (cnt_q < IDLE) begin
        da_d[8*int'(cnt_q) +: 8] = rx_byte;
        cnt_d = cnt_q + CNTW'(1);
        if (cnt_q == LAST) begin
          vld_d = 1'b1;
          acc_d = match;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
      da_q  <= '0;
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else if (rx_vld) begin
      cnt_q <= cnt_d;
      da_q  <= da_d;
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign da      = da_q;
  assign dec_vld = vld_q;
  assign dec_acc = acc_q;

endmodule

// File: rtl/rx_daf_filter.sv
module rx_daf_filter
  import rx_daf_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        rx_vld,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        decision_valid,
  output logic        accept
);

  mac_t            uc_addr;
  logic            promisc;
  logic            mc_we;
  logic [IDXW-1:0] mc_idx;
  mac_t            mc_addr;
  logic            mc_set;
  mac_t            probe;
  mac_t            da;
  logic            mc_hit;

  rx_daf_cfg #(.SLOTS(SLOTS)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .uc_addr (uc_addr),
    .promisc (promisc),
    .mc_we   (mc_we),
    .mc_idx  (mc_idx),
    .mc_addr (mc_addr),
    .mc_set  (mc_set)
  );

  rx_daf_cam #(.SLOTS(SLOTS)) cam_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mc_we),
    .wr_idx  (mc_idx),
    .wr_addr (mc_addr),
    .wr_set  (mc_set),
    .probe   (probe),
    .hit     (mc_hit)
  );

  rx_daf_capture cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_vld  (rx_vld),
    .rx_sof  (rx_sof),
    .rx_byte (rx_byte),
    .uc_addr (uc_addr),
    .promisc (promisc),
    .mc_hit  (mc_hit),
    .probe   (probe),
    .da      (da),
    .dec_vld (decision_valid),
    .dec_acc (accept)
  );

endmodule

// File: rtl/rx_daf_filter_chk.sv
module rx_daf_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_vld,
  input logic        rx_sof,
  input logic        decision_valid,
  input logic        accept,
  input logic [47:0] da,
  input logic        promisc
);

  p_rise_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_valid) |-> $past(rx_vld) && !$past(rx_sof));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid && !(rx_vld && rx_sof) |=> decision_valid && $stable(accept));

  p_sof_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld && rx_sof |=> !decision_valid);

  p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_valid) && (&da) |-> accept);

  p_promisc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_valid) && $past(promisc) |-> accept);

  p_acc_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> decision_valid);

endmodule

bind rx_daf_filter rx_daf_filter_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_vld         (rx_vld),
  .rx_sof         (rx_sof),
  .decision_valid (decision_valid),
  .accept         (accept),
  .da             (da),
  .promisc        (promisc)
);

// File: tb/rx_daf_filter_tb.sv
module rx_daf_filter_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rx_vld;
  logic        rx_sof;
  logic [7:0]  rx_byte;
  logic        decision_valid;
  logic        accept;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rx_daf_filter dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_sel        (cfg_sel),
    .cfg_wdata      (cfg_wdata),
    .rx_vld         (rx_vld),
    .rx_sof         (rx_sof),
    .rx_byte        (rx_byte),
    .decision_valid (decision_valid),
    .accept         (accept)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  logic [47:0] m_uc;
  logic [47:0] m_mc [4];
  bit          m_mcv [4];
  logic [31:0] m_stage;
  bit          m_prom;
  int          m_cnt;
  logic [47:0] m_da;
  bit          m_dv, m_acc;

  function automatic bit m_match(logic [47:0] a);
    bit r = m_prom || (a == m_uc) || (a == 48'hFFFF_FFFF_FFFF);
    foreach (m_mc[i]) if (m_mcv[i] && m_mc[i] == a) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_uc = '0; m_stage = '0; m_prom = 0; m_cnt = 6; m_da = '0; m_dv = 0; m_acc = 0;
      foreach (m_mc[i]) begin m_mc[i] = '0; m_mcv[i] = 0; end
    end else begin
      if (rx_vld) begin
        if (rx_sof) begin
          m_da = {40'd0, rx_byte}; m_cnt = 1; m_dv = 0; m_acc = 0;
        end else if (m_cnt < 6) begin
          m_da[8*m_cnt +: 8] = rx_byte;
          m_cnt++;
          if (m_cnt == 6) begin m_dv = 1; m_acc = m_match(m_da); end
        end
      end
      if (cfg_wr) begin
        case (cfg_sel)
          3'd0: m_uc[31:0] = cfg_wdata;
          3'd1: m_uc[47:32] = cfg_wdata[15:0];
          3'd2: m_stage = cfg_wdata;
          3'd3: if (cfg_wdata[23:16] < 8'd4) begin
                  m_mc[cfg_wdata[17:16]]  = {cfg_wdata[15:0], m_stage};
                  m_mcv[cfg_wdata[17:16]] = ({cfg_wdata[15:0], m_stage} != 48'd0);
                end
          3'd4: m_prom = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // Compare against the model on every clock (R10 timing, R9 decision)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (decision_valid !== m_dv || accept !== (m_dv & m_acc)) begin
        errors++;
        $display("FAIL R10/R9 model compare: actual valid=%0b accept=%0b expected valid=%0b accept=%0b",
                 decision_valid, accept, m_dv, m_dv & m_acc);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_mc(input int slot, input logic [47:0] a);
    cfg_write(3'd2, a[31:0]);
    cfg_write(3'd3, {8'd0, 8'(slot), a[47:32]});
  endtask

  // Sends a frame; leaves the bench at the negedge right after the sixth byte was sampled
  task automatic send_da(input logic [47:0] a);
    @(negedge clk);
    rx_vld = 1'b1; rx_sof = 1'b1; rx_byte = a[7:0];
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      rx_sof = 1'b0; rx_byte = a[8*k +: 8];
    end
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input logic exp, input string req);
    send_da(a);
    chk(decision_valid, 1'b1, req);
    chk(accept, exp, req);
  endtask

  localparam logic [47:0] UC  = 48'h3322_1135_0A02;
  localparam logic [47:0] MC0 = 48'h0100_005E_0001;
  localparam logic [47:0] MC2 = 48'h4400_0033_3301;
  localparam logic [47:0] MC9 = 48'h7700_0033_3301;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
    rx_vld = 0; rx_sof = 0; rx_byte = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(decision_valid, 1'b0, "R1 reset valid");
    chk(accept, 1'b0, "R1 reset accept");
    frame(MC0, 1'b0, "R1 empty table drops");

    // R2, R3: station address with junk in reserved upper bits
    cfg_write(3'd0, UC[31:0]);
    cfg_write(3'd1, {16'hABCD, UC[47:32]});
    frame(UC, 1'b1, "R2 unicast accepted");
    frame(UC ^ 48'h0100_0000_0000, 1'b0, "R9 byte5 differs dropped");
    frame(UC ^ 48'h0000_0000_0001, 1'b0, "R9 byte0 differs dropped");
    cfg_write(3'd1, {16'h0000, UC[47:32]});
    frame(UC, 1'b1, "R3 reserved bits no effect");

    // R4 multicast
    set_mc(0, MC0);
    set_mc(2, MC2);
    frame(MC0, 1'b1, "R4 slot0 hit");
    frame(MC2, 1'b1, "R4 slot2 hit");
    cfg_write(3'd2, 32'h1234_5678);
    frame(MC2, 1'b1, "R4 staged word alone commits nothing");

    // R5 invalidate slot 2
    set_mc(2, 48'd0);
    frame(MC2, 1'b0, "R5 emptied slot drops");
    frame(MC0, 1'b1, "R5 other slot kept");

    // R6 out-of-range slot 4
    set_mc(4, MC9);
    frame(MC9, 1'b0, "R6 slot4 write ignored");
    frame(MC0, 1'b1, "R6 slot0 untouched");

    // R7 broadcast
    frame(48'hFFFF_FFFF_FFFF, 1'b1, "R7 broadcast");

    // R8 promiscuous
    cfg_write(3'd4, 32'h1);
    frame(48'h0000_0BAD_BEEF, 1'b1, "R8 promisc accepts");
    cfg_write(3'd4, 32'h0);
    frame(48'h0000_0BAD_BEEF, 1'b0, "R8 promisc cleared");

    // R10 timing and hold across trailing bytes
    @(negedge clk);
    rx_vld = 1; rx_sof = 1; rx_byte = UC[7:0];
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      chk(decision_valid, 1'b0, "R10 not valid before sixth byte");
      rx_sof = 0; rx_byte = UC[8*k +: 8];
    end
    @(negedge clk);
    chk(decision_valid, 1'b1, "R10 valid after sixth byte");
    rx_byte = 8'hFF;
    repeat (3) @(negedge clk);
    rx_vld = 0;
    chk(decision_valid, 1'b1, "R10 held over payload");
    chk(accept, 1'b1, "R10 accept held over payload");

    // R11 start clears decision; aborted frame then restart
    @(negedge clk);
    rx_vld = 1; rx_sof = 1; rx_byte = 8'h55;
    @(negedge clk);
    chk(decision_valid, 1'b0, "R11 start clears valid");
    rx_sof = 0; rx_byte = 8'h66;
    @(negedge clk);
    rx_vld = 0;
    frame(UC, 1'b1, "R11 restart after short frame");

    // Mixed random traffic, compared every clock with the model
    for (int n = 0; n < 40; n++) begin
      logic [47:0] a;
      int pick = $urandom_range(0, 4);
      a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (pick == 0) a = UC;
      if (pick == 1) a = MC0;
      if (pick == 2) a = 48'hFFFF_FFFF_FFFF;
      send_da(a);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule